// File: doc/BRIEF.md
# FM0 Timing-Checking Decoder

This block recovers data bits from an FM0 (bi-phase space) line while checking the timing of every transition against a run-time bit period. The period is given as a Tari length in clock cycles. A counter restarts at each bit boundary. The block then classifies the next transition by when it arrives:

- a transition near half a Tari is the mid-bit change of a zero;
- a transition near a full Tari with no mid-bit change is a one;
- a level held well beyond one Tari is the trailing dummy one that closes the signalling.

Any interval outside its tolerance window sends the block into a sticky error state, and a cause code says which window was broken.

An outer state machine waits for the first transition and then hands control to an inner timing machine. The inner machine counts, decides and emits, and it returns control once the terminator has been recognised. The line is expected to be synchronised to `clk` already. Recognising the preamble and grouping the bits into words are left to neighbouring blocks.

The decoded bits leave on a valid-only stream. There is no ready signal, because the air line cannot be paused. The consumer must take each `bit_valid` pulse in the cycle it appears. No back-pressure is possible, and a missed pulse is a lost bit.

Top module: `fm0_tari_decoder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first transition, `bit_valid`, `eos` and `err` are 0 and `err_code` is 0.
- R2: Take a bit that starts at a transition counted as interval 0. If the next transition arrives after k cycles with 10k in [4T, 6T] (T = `tari_cycles`), a 0 is decoded. `bit_valid` is high with `bit_data` = 0 in the cycle after the clock edge that first samples that transition.
- R3: If no transition falls in the half window and the next transition arrives at k with 10k >= 9T and 100k <= 101T, a 1 is decoded, strobed in the cycle after that edge. That transition starts the next bit.
- R4: After a mid-bit transition, the closing transition must arrive at a total k from the bit start with 10k >= 9T and 100k <= 101T. Otherwise the block enters error with code 2 (full-bit violation).
- R5: A first transition with 10k < 4T enters error with code 1 (half-bit violation).
- R6: A first transition with 6T < 10k < 9T enters error with code 2.
- R7: A level held beyond 100k > 101T is a terminator. A transition with 10k in [15T, 17T] gives one `eos` pulse in the cycle after that edge, and the block goes back to waiting, so the next transition starts a new frame. A transition with 100k > 101T and 10k < 15T enters error with code 3.
- R8: If the terminator level reaches 10k > 17T, the block enters error with code 4 (timeout).
- R9: In error, `err` stays high, `err_code` stays constant, and no `bit_valid` or `eos` appears, whatever the line does. Clearing `enable` returns `err` and `err_code` to 0 in the next cycle. While `enable` is low, transitions are ignored and nothing is emitted.
- R10: For `tari_cycles` >= 8, each decoded bit gives exactly one single-cycle `bit_valid` pulse, and `bit_valid` and `eos` are never high together.
- R11: The windows follow the `tari_cycles` value present at run time, with no rebuild.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run; low clears state and error |
| tari_cycles | input | TARI_W | Tari length in clock cycles |
| line_in | input | 1 | Synchronised FM0 line |
| bit_valid | output | 1 | One-cycle strobe per decoded bit |
| bit_data | output | 1 | Decoded bit, valid with `bit_valid` |
| eos | output | 1 | One-cycle end-of-signalling strobe |
| err | output | 1 | Sticky timing error flag |
| err_code | output | 3 | 0 none, 1 half-bit, 2 full-bit, 3 terminator, 4 timeout |

## Verification
The bound checker watches several rules on every cycle:

- the strobes are one cycle long and never coincide;
- an error is silent and stable while enabled;
- a low `enable` clears everything on the next edge;
- the error flag and the cause code agree.

Whether an interval is classified correctly can only be shown by the bench's scenarios. These sweep the mid-bit, full-bit, closing and terminator intervals one cycle at a time across every window boundary. They also decode multi-bit frames at three Tari values and chain frames back to back, and the bench compares the recovered bits, terminator pulses and cause codes against an arithmetic model.

// File: rtl/fm0_dec_pkg.sv
package fm0_dec_pkg;
  localparam int ERR_W = 3;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE    = 3'd0,
    ERR_HALF    = 3'd1,
    ERR_FULL    = 3'd2,
    ERR_TERM    = 3'd3,
    ERR_TIMEOUT = 3'd4
  } fm0_err_e;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_HALF,
    TS_REST,
    TS_DUMMY,
    TS_CLEAR,
    TS_ERR
  } fm0_tstate_e;

  typedef enum logic {
    OS_WAIT,
    OS_DECODE
  } fm0_ostate_e;
endpackage

// File: rtl/fm0_edge_det.sv
module fm0_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic toggled
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_in;
  end

  assign toggled = line_in ^ prev_q;
endmodule

// File: rtl/fm0_window_cmp.sv
module fm0_window_cmp #(
  parameter int TARI_W = 12,
  parameter int CNT_W  = TARI_W + 1
) (
  input  logic [TARI_W-1:0] tari,
  input  logic [CNT_W-1:0]  cnt,
  output logic              lt_half_lo,
  output logic              le_half_hi,
  output logic              lt_full_lo,
  output logic              le_full_hi,
  output logic              lt_dum_lo,
  output logic              le_dum_hi
);
  // 100 * max count needs 7 extra bits; one more for margin
  localparam int PW = CNT_W + 8;

  logic [PW-1:0] cw, tw, c10, c100;
  logic [PW-1:0] t4, t6, t9, t101, t15, t17;

  assign cw   = PW'(cnt);
  assign tw   = PW'(tari);
  assign c10  = cw * PW'(10);
  assign c100 = cw * PW'(100);
  assign t4   = tw * PW'(4);
  assign t6   = tw * PW'(6);
  assign t9   = tw * PW'(9);
  assign t101 = tw * PW'(101);
  assign t15  = tw * PW'(15);
  assign t17  = tw * PW'(17);

  assign lt_half_lo = c10  <  t4;
  assign le_half_hi = c10  <= t6;
  assign lt_full_lo = c10  <  t9;
  assign le_full_hi = c100 <= t101;
  assign lt_dum_lo  = c10  <  t15;
  assign le_dum_hi  = c10  <= t17;
endmodule

// File: rtl/fm0_timing_fsm.sv
module fm0_timing_fsm
  import fm0_dec_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             toggled,
  input  logic             lt_half_lo,
  input  logic             le_half_hi,
  input  logic             lt_full_lo,
  input  logic             le_full_hi,
  input  logic             lt_dum_lo,
  input  logic             le_dum_hi,
  output logic [CNT_W-1:0] cnt,
  output logic             done,
  output logic             bit_valid,
  output logic             bit_data,
  output logic             eos,
  output logic             err,
  output logic [ERR_W-1:0] err_code
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  fm0_tstate_e st, st_n;
  fm0_err_e    code, code_n;
  logic [CNT_W-1:0] cnt_n, cnt_inc;
  logic bv_n, bd_n, eos_n, in_dummy;

  assign cnt_inc  = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;
  assign in_dummy = (st == TS_DUMMY) || ((st == TS_HALF) && !le_full_hi);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    code_n = code;
    bv_n   = 1'b0;
    bd_n   = 1'b0;
    eos_n  = 1'b0;
    if (!enable) begin
      st_n   = TS_IDLE;
      cnt_n  = '0;
      code_n = ERR_NONE;
    end else if (in_dummy) begin
      if (!le_dum_hi) begin
        st_n   = TS_ERR;
        code_n = ERR_TIMEOUT;
      end else if (toggled) begin
        if (lt_dum_lo) begin
          st_n   = TS_ERR;
          code_n = ERR_TERM;
        end else begin
          eos_n = 1'b1;
          st_n  = TS_CLEAR;
          cnt_n = '0;
        end
      end else begin
        st_n  = TS_DUMMY;
        cnt_n = cnt_inc;
      end
    end else begin
      unique case (st)
        TS_IDLE: begin
          if (start) begin
            st_n  = TS_HALF;
            cnt_n = CNT_ONE;
          end
        end
        TS_HALF: begin
          if (toggled) begin
            if (lt_half_lo) begin
              st_n   = TS_ERR;
              code_n = ERR_HALF;
            end else if (le_half_hi) begin
              bv_n  = 1'b1;
              st_n  = TS_REST;
              cnt_n = cnt_inc;
            end else if (lt_full_lo) begin
              st_n   = TS_ERR;
              code_n = ERR_FULL;
            end else begin
              bv_n  = 1'b1;
              bd_n  = 1'b1;
              cnt_n = CNT_ONE;
            end
          end else begin
            cnt_n = cnt_inc;
          end
        end
        TS_REST: begin
          if (!le_full_hi || (toggled && lt_full_lo)) begin
            st_n   = TS_ERR;
            code_n = ERR_FULL;
          end else if (toggled) begin
            st_n  = TS_HALF;
            cnt_n = CNT_ONE;
          end else begin
            cnt_n = cnt_inc;
          end
        end
        TS_CLEAR: begin
          st_n  = TS_IDLE;
          cnt_n = '0;
        end
        TS_ERR:  st_n = TS_ERR;
        default: st_n = TS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TS_IDLE;
      cnt       <= '0;
      code      <= ERR_NONE;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
      eos       <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      code      <= code_n;
      bit_valid <= bv_n;
      bit_data  <= bd_n;
      eos       <= eos_n;
    end
  end

  assign done     = (st == TS_CLEAR);
  assign err      = (st == TS_ERR);
  assign err_code = code;
endmodule

// File: rtl/fm0_tari_decoder.sv
module fm0_tari_decoder
  import fm0_dec_pkg::*;
#(
  parameter int TARI_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [TARI_W-1:0] tari_cycles,
  input  logic              line_in,
  output logic              bit_valid,
  output logic              bit_data,
  output logic              eos,
  output logic              err,
  output logic [ERR_W-1:0]  err_code
);
  localparam int CNT_W = TARI_W + 1;

  fm0_ostate_e      ost;
  logic             toggled, start, done;
  logic [CNT_W-1:0] cnt;
  logic lt_half_lo, le_half_hi, lt_full_lo, le_full_hi, lt_dum_lo, le_dum_hi;

  fm0_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (line_in),
    .toggled (toggled)
  );

  // Outer machine: wait for first activity, then hand over to the timing FSM
  assign start = (ost == OS_WAIT) && enable && toggled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ost <= OS_WAIT;
    else if (!enable || done)  ost <= OS_WAIT;
    else if (start)            ost <= OS_DECODE;
  end

  fm0_window_cmp #(.TARI_W(TARI_W), .CNT_W(CNT_W)) u_win (
    .tari       (tari_cycles),
    .cnt        (cnt),
    .lt_half_lo (lt_half_lo),
    .le_half_hi (le_half_hi),
    .lt_full_lo (lt_full_lo),
    .le_full_hi (le_full_hi),
    .lt_dum_lo  (lt_dum_lo),
    .le_dum_hi  (le_dum_hi)
  );

  fm0_timing_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .start      (start),
    .toggled    (toggled),
    .lt_half_lo (lt_half_lo),
    .le_half_hi (le_half_hi),
    .lt_full_lo (lt_full_lo),
    .le_full_hi (le_full_hi),
    .lt_dum_lo  (lt_dum_lo),
    .le_dum_hi  (le_dum_hi),
    .cnt        (cnt),
    .done       (done),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .eos        (eos),
    .err        (err),
    .err_code   (err_code)
  );
endmodule

// File: rtl/fm0_tari_decoder_chk.sv
module fm0_tari_decoder_chk #(
  parameter int TARI_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [TARI_W-1:0] tari_cycles,
  input logic              line_in,
  input logic              bit_valid,
  input logic              bit_data,
  input logic              eos,
  input logic              err,
  input logic [2:0]        err_code
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tari_cycles >= TARI_W'(8) && bit_valid) |=> !bit_valid); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && eos)); // R10

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!bit_valid && !eos)); // R9

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err && enable) |=> (err && $stable(err_code))); // R9

  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!err && !bit_valid && !eos && err_code == 3'd0)); // R9

  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    err == (err_code != 3'd0)); // R5

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_code <= 3'd4); // R8

  AST_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !line_in && $fell(line_in)) |-> !eos || !err); // R7
endmodule

bind fm0_tari_decoder fm0_tari_decoder_chk #(.TARI_W(TARI_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .tari_cycles (tari_cycles),
  .line_in     (line_in),
  .bit_valid   (bit_valid),
  .bit_data    (bit_data),
  .eos         (eos),
  .err         (err),
  .err_code    (err_code)
);

// File: tb/fm0_tari_decoder_bench.sv
`timescale 1ns/1ps
module fm0_tari_decoder_bench;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [TW-1:0] tari = TW'(20);
  logic          line_in = 1'b0;
  logic          bit_valid, bit_data, eos, err;
  logic [2:0]    err_code;

  fm0_tari_decoder #(.TARI_W(TW)) u_fm0_tari_decoder (
    .clk (clk), .rst_n (rst_n), .enable (enable), .tari_cycles (tari),
    .line_in (line_in), .bit_valid (bit_valid), .bit_data (bit_data),
    .eos (eos), .err (err), .err_code (err_code)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [63:0] rec_bits;
  int rec_n, rec_eos;
  bit recording = 0;

  always @(negedge clk) begin
    if (recording) begin
      if (bit_valid) begin
        if (rec_n < 64) rec_bits[rec_n] = bit_data;
        rec_n = rec_n + 1;
      end
      if (eos) rec_eos = rec_eos + 1;
    end
  end

  int ivl [0:31];
  int n_ivl;
  logic [63:0] exp_bits;
  int exp_n, exp_eos, exp_code;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push_exp(bit b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  // Arithmetic model of the interval rules
  task automatic model(int t);
    int mode, acc, k, tot;
    bit stop, idle;
    mode = 0; acc = 0; stop = 0; idle = 0;
    exp_bits = '0; exp_n = 0; exp_eos = 0; exp_code = 0;
    for (int i = 0; i < n_ivl; i++) begin
      if (stop) break;
      k = ivl[i];
      if (idle) begin
        idle = 0; mode = 0;
      end else if (mode == 0) begin
        if (100*k > 101*t) begin
          if (10*k > 17*t)      begin exp_code = 4; stop = 1; end
          else if (10*k < 15*t) begin exp_code = 3; stop = 1; end
          else begin exp_eos++; idle = 1; end
        end else if (10*k < 4*t) begin exp_code = 1; stop = 1; end
        else if (10*k <= 6*t)    begin push_exp(1'b0); mode = 1; acc = k; end
        else if (10*k < 9*t)     begin exp_code = 2; stop = 1; end
        else push_exp(1'b1);
      end else begin
        tot = acc + k;
        if (10*tot < 9*t || 100*tot > 101*t) begin exp_code = 2; stop = 1; end
        else mode = 0;
      end
    end
    if (!stop && !idle) exp_code = (mode == 1) ? 2 : 4;
  endtask

  task automatic run(int t, string tag, bit en = 1'b1);
    logic [63:0] mask;
    enable = 1'b0; tari = TW'(t); line_in = 1'b0;
    repeat (3) @(negedge clk);
    rec_n = 0; rec_eos = 0; rec_bits = '0; recording = 1;
    enable = en;
    @(negedge clk);
    line_in = ~line_in;
    for (int i = 0; i < n_ivl; i++) begin
      repeat (ivl[i]) @(negedge clk);
      line_in = ~line_in;
    end
    repeat (60) @(negedge clk);
    recording = 0;
    if (en) model(t);
    else begin exp_bits = '0; exp_n = 0; exp_eos = 0; exp_code = 0; end
    mask = (exp_n == 0) ? 64'd0 : ((64'd1 << exp_n) - 64'd1);
    chk((rec_n == exp_n) && ((rec_bits & mask) == (exp_bits & mask)),
        tag, "bit count/content", rec_n, exp_n);
    chk(rec_eos == exp_eos, tag, "eos pulses", rec_eos, exp_eos);
    chk(err == (exp_code != 0), tag, "err flag", int'(err), int'(exp_code != 0));
    chk(int'(err_code) == exp_code, tag, "err_code", int'(err_code), exp_code);
  endtask

  task automatic load_byte(int t, logic [7:0] v);
    n_ivl = 0;
    for (int b = 7; b >= 0; b--) begin
      if (v[b]) begin ivl[n_ivl] = t; n_ivl++; end
      else begin
        ivl[n_ivl] = t/2; ivl[n_ivl+1] = t - t/2; n_ivl += 2;
      end
    end
    ivl[n_ivl] = (16*t)/10; n_ivl++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [0:3];
    int taris [0:2];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h00; pats[3] = 8'hFF;
    taris[0] = 16; taris[1] = 20; taris[2] = 25;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!bit_valid && !eos && !err && err_code == 0, "R1", "outputs in reset", int'(err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bit_valid && !eos && !err && err_code == 0, "R1", "outputs after reset", int'(err_code), 0);

    // R2 R5 R6: mid-bit interval sweep
    for (int k = 2; k <= 17; k++) begin
      ivl[0] = k; ivl[1] = 20 - k; ivl[2] = 32; n_ivl = 3;
      run(20, "R2 R5 R6");
    end
    // R3 R6 R7 R8: first interval sweep without a mid-bit change
    for (int k = 13; k <= 38; k++) begin
      ivl[0] = k; ivl[1] = 32; n_ivl = 2;
      run(20, "R3 R6 R7 R8");
    end
    // R7 R8: terminator length sweep after a one
    for (int d = 24; d <= 38; d++) begin
      ivl[0] = 20; ivl[1] = d; n_ivl = 2;
      run(20, "R7 R8");
    end
    // R4: closing interval sweep after a mid-bit change
    for (int r = 4; r <= 14; r++) begin
      ivl[0] = 10; ivl[1] = r; ivl[2] = 32; n_ivl = 3;
      run(20, "R4");
    end
    // R2 R3 R10 R11: byte frames at several Tari values
    foreach (taris[ti]) begin
      foreach (pats[pi]) begin
        load_byte(taris[ti], pats[pi]);
        run(taris[ti], "R2 R3 R10 R11");
      end
    end
    // R7: back-to-back frames, return to waiting after eos
    ivl[0] = 20; ivl[1] = 32; ivl[2] = 50; ivl[3] = 10; ivl[4] = 10;
    ivl[5] = 20; ivl[6] = 32; n_ivl = 7;
    run(20, "R7");
    // R9: edges after an error change nothing
    ivl[0] = 3; ivl[1] = 10; ivl[2] = 10; ivl[3] = 20; ivl[4] = 32; n_ivl = 5;
    run(20, "R9");
    // R9: enable low clears the error in the next cycle
    enable = 1'b0;
    @(negedge clk);
    chk(!err && err_code == 0, "R9", "clear on disable", int'(err_code), 0);
    // R9: disabled decoder ignores a valid frame
    load_byte(20, 8'h5A);
    run(20, "R9", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule